// File: doc/BRIEF.md
# Quad Down-Counting Timer Unit

This block provides four independent down-counters on a word-addressed register port. It also has a shared interrupt section. Software programs each channel with a start value, a reload value and a control byte, then reads back the live count or waits for the channel's interrupt.

Each channel can count in three ways:
- It can run free and wrap to the all-ones value of its width.
- It can run periodically and reload from a separate reload register.
- It can run once and stop at zero.

The count advances on the system clock divided by 1, 16 or 256, and the counter is 16 or 32 bits wide. A reload value written while the channel runs is used only at the next underflow. The count in progress is not disturbed.

The interrupt section latches one raw bit per channel when that channel underflows. It gates the raw bits with a mask register and drives one interrupt line per channel. Software clears raw bits by writing ones to a clear register.

Top module: `quad_down_timer`

## Requirements
- R1: After reset every readable register reads zero and all interrupt lines are low.
- R2: Channel n's registers sit at byte offset 0x10+0x10*n: start value +0x0, live count +0x4, control +0x8, reload value +0xC. Writing the start value loads the counter in the write cycle, and an enabled channel at divide-by-1 then decrements once per clock.
- R3: Control bits [3:2] set the tick divider. Code 00 divides by 1, 01 by 16, and 10 and 11 both by 256. The divider restarts when the start value is written and when control bit 7 (enable) goes from 0 to 1.
- R4: In free-running mode (control bits 6 and 0 both clear), a tick at count zero wraps the count. It wraps to 0xFFFF when control bit 1 is 0 and to 0xFFFFFFFF when control bit 1 is 1.
- R5: With control bit 6 set and bit 0 clear, a tick at count zero reloads the reload value. Writing the reload value never changes the running count.
- R6: With control bit 0 set, a tick at count zero raises the interrupt once. The count then holds at zero until the start value or the control register is written again.
- R7: When control bit 1 is 0 the counter is 16 bits wide: written values are truncated to their low 16 bits.
- R8: A tick at count zero sets raw status bit n (offset 0x04) for channel n. The bit stays set until a 1 is written to bit n of the clear register (offset 0x0C). Writes to the raw status register are ignored.
- R9: Masked status (offset 0x08) equals raw status AND the mask register (offset 0x00, read/write). Interrupt line n follows masked bit n.
- R10: A channel with control bit 7 clear holds its count.
- R11: Channels are independent: activity on one channel never changes another channel's count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; also the timer tick source |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address, bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 4 | One interrupt line per channel |

## Verification
The checker watches several rules on every cycle:
- An underflow must leave its raw bit set, and a raw bit must stay set until a matching clear write.
- An interrupt line may be high only when both its raw bit and its mask bit are set.
- A disabled channel must hold its count, and a stopped one-shot channel must stay at zero.
- A 16-bit channel must never carry upper bits.

Only the directed scenarios can show that each mode produces the right value at the right time. These cover the exact cycle at which each divider setting first decrements, the wrap and reload values, and a reload change taking effect only at the next underflow.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  localparam int DATA_W  = 32;
  localparam int CTRL_W  = 8;
  localparam int PRE_W   = 8;

  localparam int CTRL_EN   = 7;
  localparam int CTRL_PER  = 6;
  localparam int CTRL_DIVH = 3;
  localparam int CTRL_DIVL = 2;
  localparam int CTRL_WIDE = 1;
  localparam int CTRL_ONE  = 0;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 8'hCF;

  typedef enum logic [1:0] {
    REG_START = 2'd0,
    REG_COUNT = 2'd1,
    REG_CTRL  = 2'd2,
    REG_RELOAD = 2'd3
  } chan_reg_e;

  typedef enum logic [1:0] {
    IRQ_MASK   = 2'd0,
    IRQ_RAW    = 2'd1,
    IRQ_MASKED = 2'd2,
    IRQ_CLEAR  = 2'd3
  } irq_reg_e;

  function automatic logic [DATA_W-1:0] width_mask(input logic wide);
    return wide ? {DATA_W{1'b1}} : {{(DATA_W-16){1'b0}}, 16'hFFFF};
  endfunction
endpackage

// File: rtl/qdt_prescaler.sv
module qdt_prescaler
  import qdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    case (sel_i)
      2'd0:    lim = '0;
      2'd1:    lim = PRE_W'(15);
      default: lim = PRE_W'(255);
    endcase
  end

  // >= so a divider shortened mid-run still ticks
  assign tick_o = en_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (en_i)      pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic              wr_ctrl_i,
  input  logic              wr_reload_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] start_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              expire_o,
  output logic              halt_o
);
  logic [DATA_W-1:0] start_q, cnt_q, reload_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              halt_q;
  logic              tick, restart, run;
  logic [DATA_W-1:0] cur_mask;

  assign cur_mask = width_mask(ctrl_q[CTRL_WIDE]);
  assign run      = ctrl_q[CTRL_EN] && !halt_q;
  assign restart  = wr_start_i || (wr_ctrl_i && wdata_i[CTRL_EN] && !ctrl_q[CTRL_EN]);

  qdt_prescaler u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (run),
    .restart_i (restart),
    .sel_i     (ctrl_q[CTRL_DIVH:CTRL_DIVL]),
    .tick_o    (tick)
  );

  assign expire_o = tick && (cnt_q == '0) && !wr_start_i && !wr_ctrl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q  <= '0;
      reload_q <= '0;
      ctrl_q   <= '0;
    end else begin
      if (wr_start_i)  start_q  <= wdata_i;
      if (wr_reload_i) reload_q <= wdata_i;
      if (wr_ctrl_i)   ctrl_q   <= wdata_i[CTRL_W-1:0] & CTRL_KEEP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (wr_start_i) begin
      cnt_q  <= wdata_i & cur_mask;
      halt_q <= 1'b0;
    end else if (wr_ctrl_i) begin
      cnt_q  <= cnt_q & width_mask(wdata_i[CTRL_WIDE]);
      halt_q <= 1'b0;
    end else if (tick) begin
      if (cnt_q != '0)              cnt_q  <= cnt_q - 1'b1;
      else if (ctrl_q[CTRL_ONE])    halt_q <= 1'b1;
      else if (ctrl_q[CTRL_PER])    cnt_q  <= reload_q & cur_mask;
      else                          cnt_q  <= cur_mask;
    end
  end

  assign start_o  = start_q;
  assign cnt_o    = cnt_q;
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign halt_o   = halt_q;
endmodule

// File: rtl/qdt_irq.sv
module qdt_irq #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] expire_i,
  input  logic              wr_mask_i,
  input  logic              wr_clear_i,
  input  logic [NUM_CH-1:0] wbits_i,
  output logic [NUM_CH-1:0] raw_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] masked_o
);
  logic [NUM_CH-1:0] raw_q, mask_q, clr;

  assign clr = wr_clear_i ? wbits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr) | expire_i;  // new event wins over clear
      if (wr_mask_i) mask_q <= wbits_i;
    end
  end

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
endmodule

// File: rtl/quad_down_timer.sv
module quad_down_timer
  import qdt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int SEL_W = ADDR_W - 4;

  logic [SEL_W-1:0] slot;
  logic [1:0]       reg_sel;
  logic             wr;
  logic             unused_addr;

  assign slot        = addr_i[ADDR_W-1:4];
  assign reg_sel     = addr_i[3:2];
  assign wr          = req_i && we_i;
  assign unused_addr = ^addr_i[1:0];

  logic [NUM_CH-1:0][DATA_W-1:0] start_w, cnt_w, reload_w;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_w;
  logic [NUM_CH-1:0]             expire_w, halt_w;
  logic [NUM_CH-1:0]             raw_w, mask_w, masked_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr && (slot == SEL_W'(c + 1));
    qdt_channel u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_start_i  (hit && reg_sel == REG_START),
      .wr_ctrl_i   (hit && reg_sel == REG_CTRL),
      .wr_reload_i (hit && reg_sel == REG_RELOAD),
      .wdata_i     (wdata_i),
      .start_o     (start_w[c]),
      .cnt_o       (cnt_w[c]),
      .ctrl_o      (ctrl_w[c]),
      .reload_o    (reload_w[c]),
      .expire_o    (expire_w[c]),
      .halt_o      (halt_w[c])
    );
  end

  qdt_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .expire_i   (expire_w),
    .wr_mask_i  (wr && slot == '0 && reg_sel == IRQ_MASK),
    .wr_clear_i (wr && slot == '0 && reg_sel == IRQ_CLEAR),
    .wbits_i    (wdata_i[NUM_CH-1:0]),
    .raw_o      (raw_w),
    .mask_o     (mask_w),
    .masked_o   (masked_w)
  );

  always_comb begin
    rdata_o = '0;
    if (slot == '0) begin
      case (reg_sel)
        IRQ_MASK:   rdata_o[NUM_CH-1:0] = mask_w;
        IRQ_RAW:    rdata_o[NUM_CH-1:0] = raw_w;
        IRQ_MASKED: rdata_o[NUM_CH-1:0] = masked_w;
        default:    rdata_o = '0;
      endcase
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (slot == SEL_W'(c + 1)) begin
        case (reg_sel)
          REG_START: rdata_o = start_w[c];
          REG_COUNT: rdata_o = cnt_w[c];
          REG_CTRL:  rdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_w[c]};
          default:   rdata_o = reload_w[c];
        endcase
      end
    end
  end

  assign irq_o = masked_w;
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker
  import qdt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          we_i,
  input logic [ADDR_W-1:0]             addr_i,
  input logic [DATA_W-1:0]             wdata_i,
  input logic [NUM_CH-1:0]             irq_o,
  input logic [NUM_CH-1:0]             raw_w,
  input logic [NUM_CH-1:0]             mask_w,
  input logic [NUM_CH-1:0]             expire_w,
  input logic [NUM_CH-1:0]             halt_w,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_w,
  input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_w
);
  localparam int SEL_W = ADDR_W - 4;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic ch_wr, clr_hit;
    assign ch_wr   = req_i && we_i && (addr_i[ADDR_W-1:4] == SEL_W'(c + 1));
    assign clr_hit = req_i && we_i && (addr_i[ADDR_W-1:4] == '0) &&
                     (addr_i[3:2] == 2'd3) && wdata_i[c];

    assert_expire_sets_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      expire_w[c] |=> raw_w[c]);

    assert_raw_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (raw_w[c] && !clr_hit) |=> raw_w[c]);

    assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[c] |-> (raw_w[c] && mask_w[c]));

    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_w[c][CTRL_EN] && !ch_wr) |=> $stable(cnt_w[c]));

    assert_oneshot_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halt_w[c] && !ch_wr) |=> (halt_w[c] && cnt_w[c] == '0));

    assert_narrow_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_w[c][CTRL_WIDE] |-> (cnt_w[c][DATA_W-1:16] == '0));
  end
endmodule

bind quad_down_timer qdt_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_qdt_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .irq_o    (irq_o),
  .raw_w    (raw_w),
  .mask_w   (mask_w),
  .expire_w (expire_w),
  .halt_w   (halt_w),
  .cnt_w    (cnt_w),
  .ctrl_w   (ctrl_w)
);

// File: tb/tb_quad_down_timer.sv
`timescale 1ns/1ps
module tb_quad_down_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  quad_down_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] ch_addr(input int ch, input int r);
    return 8'(16 + 16 * ch + 4 * r);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // called at a negedge, returns one negedge later
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1;
    check(tag, rdata_o, exp);
    req_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    for (int ch = 0; ch < 4; ch++)
      for (int r = 0; r < 4; r++) rd(ch_addr(ch, r), 32'h0, "R1 channel reg after reset");
    rd(8'h00, 0, "R1 mask after reset");
    rd(8'h04, 0, "R1 raw after reset");
    check("R1 irq after reset", {28'h0, irq_o}, 0);
  endtask

  task automatic t_hold_disabled;
    wr(ch_addr(2, 0), 32'h0000_1234);
    rd(ch_addr(2, 1), 32'h1234, "R2 start value loads count");
    wait_cyc(5);
    rd(ch_addr(2, 1), 32'h1234, "R10 disabled channel holds");
  endtask

  task automatic t_free32;
    wr(ch_addr(0, 0), 100);
    wr(ch_addr(0, 2), 32'h82);
    rd(ch_addr(0, 2), 32'h82, "R2 control readback");
    wait_cyc(10);
    rd(ch_addr(0, 1), 90, "R2 decrement per clock");
    wr(ch_addr(0, 0), 3);
    rd(ch_addr(0, 1), 3, "R2 reload while running");
    wait_cyc(3);
    rd(ch_addr(0, 1), 0, "R4 reaches zero");
    rd(8'h04, 0, "R8 no raw before underflow");
    wait_cyc(1);
    rd(ch_addr(0, 1), 32'hFFFF_FFFF, "R4 wrap 32-bit");
    rd(8'h04, 32'h1, "R8 raw bit 0 set");
    wr(ch_addr(0, 2), 0);
    wr(8'h0C, 32'h1);
    rd(8'h04, 0, "R8 clear write");
  endtask

  task automatic t_free16;
    wr(ch_addr(1, 0), 32'h0001_0002);
    rd(ch_addr(1, 1), 2, "R7 16-bit truncation");
    wr(ch_addr(1, 2), 32'h80);
    wait_cyc(2);
    rd(ch_addr(1, 1), 0, "R4 16-bit reaches zero");
    wait_cyc(1);
    rd(ch_addr(1, 1), 32'h0000_FFFF, "R4 wrap 16-bit");
    rd(8'h04, 32'h2, "R8 raw bit 1 only");
    wr(ch_addr(1, 2), 0);
    wr(8'h0C, 32'h2);
    rd(8'h04, 0, "R8 clear bit 1");
  endtask

  task automatic t_prescale;
    wr(ch_addr(3, 0), 50);
    wr(ch_addr(3, 2), 32'h86);
    wait_cyc(15);
    rd(ch_addr(3, 1), 50, "R3 div16 before 16th clock");
    wait_cyc(1);
    rd(ch_addr(3, 1), 49, "R3 div16 first tick");
    wait_cyc(16);
    rd(ch_addr(3, 1), 48, "R3 div16 second tick");
    wr(ch_addr(3, 0), 50);
    wait_cyc(15);
    rd(ch_addr(3, 1), 50, "R3 restart on start write");
    wait_cyc(1);
    rd(ch_addr(3, 1), 49, "R3 tick after restart");
    wr(ch_addr(3, 2), 0);
    wr(ch_addr(3, 0), 10);
    wr(ch_addr(3, 2), 32'h8A);
    wait_cyc(255);
    rd(ch_addr(3, 1), 10, "R3 div256 before tick");
    wait_cyc(1);
    rd(ch_addr(3, 1), 9, "R3 div256 tick");
    wr(ch_addr(3, 2), 0);
    wr(ch_addr(3, 0), 10);
    wr(ch_addr(3, 2), 32'h8E);
    wait_cyc(255);
    rd(ch_addr(3, 1), 10, "R3 code 11 before tick");
    wait_cyc(1);
    rd(ch_addr(3, 1), 9, "R3 code 11 tick");
    wr(ch_addr(3, 2), 0);
  endtask

  task automatic t_periodic;
    wr(ch_addr(0, 3), 5);
    wr(ch_addr(0, 0), 2);
    wr(ch_addr(0, 2), 32'hC2);
    wait_cyc(2);
    rd(ch_addr(0, 1), 0, "R5 periodic at zero");
    wait_cyc(1);
    rd(ch_addr(0, 1), 5, "R5 reload value used");
    rd(8'h04, 32'h1, "R8 periodic underflow raw");
    wait_cyc(1);
    rd(ch_addr(0, 1), 4, "R5 count after reload");
    wr(ch_addr(0, 3), 9);
    rd(ch_addr(0, 1), 3, "R5 reload write leaves count");
    rd(ch_addr(0, 3), 9, "R5 reload readback");
    wait_cyc(3);
    rd(ch_addr(0, 1), 0, "R5 zero again");
    wait_cyc(1);
    rd(ch_addr(0, 1), 9, "R5 new reload at next underflow");
    check("R9 irq masked off", {28'h0, irq_o}, 0);
    wr(8'h00, 32'h1);
    check("R9 irq line 0", {28'h0, irq_o}, 32'h1);
    rd(8'h08, 32'h1, "R9 masked status");
    rd(8'h00, 32'h1, "R9 mask readback");
    wr(8'h04, 32'hF);
    rd(8'h04, 32'h1, "R8 raw write ignored");
    wr(8'h0C, 32'h1);
    check("R9 irq drops after clear", {28'h0, irq_o}, 0);
    rd(8'h08, 0, "R9 masked cleared");
    wr(ch_addr(0, 2), 0);
    wr(8'h0C, 32'hF);
    wr(8'h00, 0);
  endtask

  task automatic t_oneshot;
    wr(ch_addr(1, 0), 2);
    wr(ch_addr(1, 2), 32'h83);
    wait_cyc(2);
    rd(ch_addr(1, 1), 0, "R6 one-shot at zero");
    wait_cyc(1);
    rd(ch_addr(1, 1), 0, "R6 stops at zero");
    rd(8'h04, 32'h2, "R6 one-shot interrupt");
    wr(8'h0C, 32'h2);
    wait_cyc(20);
    rd(ch_addr(1, 1), 0, "R6 holds at zero");
    rd(8'h04, 0, "R6 no second interrupt");
    wr(ch_addr(1, 0), 1);
    rd(ch_addr(1, 1), 1, "R6 restart by start write");
    wait_cyc(2);
    rd(8'h04, 32'h2, "R6 fires again after restart");
    wr(ch_addr(1, 2), 0);
    wr(8'h0C, 32'h2);
  endtask

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    wait_cyc(1);
    t_reset();
    t_hold_disabled();
    t_free32();
    t_free16();
    t_prescale();
    t_periodic();
    t_oneshot();
    rd(ch_addr(2, 1), 32'h1234, "R11 untouched channel unchanged");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule